// File: doc/BRIEF.md
# I2C Byte-Command Bus Master

This block is an I2C bus master driven one bus operation at a time by a host. The host programs a clock divider, optionally loads a data byte, and then writes a command word that carries a launch bit together with a four-bit operation code. The engine performs that single operation on the bus: a start, a repeated start, a stop, a byte transmission with acknowledge sampling, or a byte reception that ends with ACK or NACK. When the operation finishes, it reports a two-bit completion code and sets a pending flag. The flag can drive an interrupt line.

Both bus wires are open drain. For each wire the block provides a pull-low enable output and an input that reads the actual line level. The SCL input is also used for basic clock stretching: while the engine has released SCL but the line is still low, its timebase stops counting. All register accesses are byte wide on a small offset map. Reads are combinational from the selected register.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, and while bit 0 of the control register (offset 0x0) is 1, the engine is idle. Both wires are released, busy, status and the pending flag are 0, and bus ownership is dropped. Commands written during this time are ignored. Clearing the bit returns the engine to normal operation, and because ownership was lost, a following byte command aborts.
- R2: Offsets 0x1 (divider, 8 bits), 0x3 (data, 8 bits), 0xA (interrupt enable, bit 0 only) and 0x0 (bit 0 only) read back what was written. Offset 0x2 reads as {busy in bit 7, completion status in bits 6:5, 0 in bit 4, last accepted opcode in bits 3:0}.
- R3: A write to offset 0x2 launches a command only when bit 7 is 1 and the engine is idle. Launching sets busy and clears the status to 0. A write with bit 7 at 0, or any write while busy, changes nothing.
- R4: One SCL bit period lasts 64*(D+1) clocks, where D is the divider value, and is split into four quarters of 16*(D+1) clocks. During byte commands, SDA changes only while SCL is low.
- R5: Opcode 1 (start) lowers SDA while SCL is high and then lowers SCL. It ends with status 0 and the bus owned.
- R6: Opcode 3 shifts out the data register MSB first and then releases SDA for a ninth clock. The status is 1 if SDA reads low at mid-high of that clock, and 2 otherwise.
- R7: Opcodes 6 and 7 sample eight bits MSB first at mid-high of SCL and store the byte in the data register. On the ninth clock they drive SDA low (opcode 6) or release it (opcode 7). The status is 0.
- R8: Opcode 10 (stop) raises SDA while SCL is high, leaves both wires released and drops ownership. The status is 0, or 3 if SDA still reads low at the end of the stop.
- R9: An opcode outside {1,2,3,6,7,10}, or any opcode other than 1 issued while the bus is not owned, completes at once with status 3 and causes no bus activity.
- R10: Every completion sets the pending flag. Writing 1 to bit 0 of offset 0x8 clears it, and a completion in the same cycle wins over the clear. The interrupt output is high exactly when the flag is pending and enable bit 0 is 1.
- R11: Opcode 2, and opcode 1 while the bus is already owned, releases SDA while SCL is low, then raises SCL, then lowers SDA. It ends with status 0 and the bus owned.
- R12: While the engine releases SCL but the SCL input reads low, quarter counting pauses, and the command finishes later by the stretched time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (4) | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq | output | 1 | Completion interrupt |
| scl_oe | output | 1 | 1 pulls SCL low |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | SDA line level |

## Verification
If the quarter or bit counter is corrupted, the SCL rise spacing changes or the ninth clock goes missing. That is visible within one bit period, through the rise count and the byte captured on the wires. A wrong ownership or status register shows up in the command-register readback at the very next completion, as an unexpected abort or ACK code. A sampling point moved into the wrong quarter corrupts the received byte in the data register. An SDA edge while SCL is high, where none should occur, is counted as a spurious start or stop by the bus monitor.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;
  // register byte offsets (host-visible decode)
  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_DIV  = 4'h1;
  localparam logic [3:0] A_CMD  = 4'h2;
  localparam logic [3:0] A_DATA = 4'h3;
  localparam logic [3:0] A_FCLR = 4'h8;
  localparam logic [3:0] A_IEN  = 4'hA;

  localparam logic [3:0] OP_START   = 4'd1;
  localparam logic [3:0] OP_RESTART = 4'd2;
  localparam logic [3:0] OP_WRITE   = 4'd3;
  localparam logic [3:0] OP_RD_ACK  = 4'd6;
  localparam logic [3:0] OP_RD_NACK = 4'd7;
  localparam logic [3:0] OP_STOP    = 4'd10;

  localparam logic [1:0] ST_OK    = 2'd0;
  localparam logic [1:0] ST_ACK   = 2'd1;
  localparam logic [1:0] ST_NOACK = 2'd2;
  localparam logic [1:0] ST_ABORT = 2'd3;

  typedef enum logic [1:0] {K_START, K_RESTART, K_STOP, K_BYTE} kind_e;

  // clocks in one quarter of an SCL period
  function automatic int quarter_len(input int div, input int mult);
    return (div + 1) * mult;
  endfunction

  function automatic logic op_known(input logic [3:0] op);
    return (op == OP_START) || (op == OP_RESTART) || (op == OP_WRITE) ||
           (op == OP_RD_ACK) || (op == OP_RD_NACK) || (op == OP_STOP);
  endfunction

  // {scl_low, sda_low} for a quarter of a command
  function automatic logic [1:0] line_pattern(input kind_e k, input logic [1:0] q,
                                              input logic bitv);
    logic [1:0] r;
    case (k)
      K_START:   r = (q == 2'd0) ? 2'b00 : (q == 2'd3) ? 2'b11 : 2'b01;
      K_RESTART: r = (q == 2'd0) ? 2'b10 : (q == 2'd1) ? 2'b00 :
                     (q == 2'd2) ? 2'b01 : 2'b11;
      K_STOP:    r = (q == 2'd0) ? 2'b11 : (q == 2'd1) ? 2'b01 : 2'b00;
      default:   r = {(q == 2'd0) || (q == 2'd3), ~bitv};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/i2cm_qtick.sv
`timescale 1ns/1ps
module i2cm_qtick import i2cm_pkg::*; #(
  parameter int DIV_W = 8,
  parameter int QMULT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [DIV_W-1:0] div,
  output logic             qtick
);
  localparam int CW = $clog2((1 << DIV_W) * QMULT);

  logic [CW-1:0] cnt, lim;

  assign lim   = CW'(quarter_len(32'(div), QMULT) - 1);
  assign qtick = run && !hold && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (!hold)     cnt <= (cnt >= lim) ? '0 : cnt + 1'b1;
  end

  // R4: quarter ticks are never back to back
  a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    qtick |=> !qtick);
  // R12: a stretched SCL freezes the quarter counter
  a_r12_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hold) |=> $stable(cnt));
endmodule

// File: rtl/i2cm_seq.sv
`timescale 1ns/1ps
module i2cm_seq import i2cm_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       go,
  input  logic [3:0] op,
  input  logic [7:0] tx,
  input  logic       qtick,
  input  logic       sda_in,
  output logic       busy,
  output logic       owned,
  output logic       done,
  output logic [1:0] status,
  output logic [7:0] rx,
  output logic       rx_load,
  output logic       scl_low,
  output logic       sda_low
);
  logic       busy_q, owned_q, done_q, rxl_q, rd_q, nack_q, ack_q;
  logic       idle_scl_q, idle_sda_q;
  logic [1:0] st_q, q_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q;
  kind_e      kind_q, kind_n;

  logic       bitv, last_q, go_ok, go_bad, byte_phase;
  logic [1:0] pat;

  assign bitv = rd_q ? ((bit_q == 4'd8) ? nack_q : 1'b1)
                     : ((bit_q == 4'd8) ? 1'b1 : sh_q[7]);
  assign pat     = line_pattern(kind_q, q_q, bitv);
  assign scl_low = busy_q ? pat[1] : idle_scl_q;
  assign sda_low = busy_q ? pat[0] : idle_sda_q;
  assign last_q  = (q_q == 2'd3) && (kind_q != K_BYTE || bit_q == 4'd8);
  assign byte_phase = busy_q && (kind_q == K_BYTE);

  assign go_ok  = go && !busy_q && op_known(op) && (owned_q || op == OP_START);
  assign go_bad = go && !busy_q && !go_ok;

  always_comb begin
    if (op == OP_START)        kind_n = owned_q ? K_RESTART : K_START;
    else if (op == OP_RESTART) kind_n = K_RESTART;
    else if (op == OP_STOP)    kind_n = K_STOP;
    else                       kind_n = K_BYTE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      busy_q <= 1'b0; owned_q <= 1'b0; done_q <= 1'b0; rxl_q <= 1'b0;
      st_q <= ST_OK; kind_q <= K_BYTE; rd_q <= 1'b0; nack_q <= 1'b0;
      q_q <= '0; bit_q <= '0; sh_q <= '0; ack_q <= 1'b0;
      idle_scl_q <= 1'b0; idle_sda_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rxl_q  <= 1'b0;
      if (go_bad) begin
        done_q <= 1'b1;
        st_q   <= ST_ABORT;
      end else if (go_ok) begin
        busy_q <= 1'b1;
        st_q   <= ST_OK;
        kind_q <= kind_n;
        rd_q   <= (op == OP_RD_ACK) || (op == OP_RD_NACK);
        nack_q <= (op == OP_RD_NACK);
        q_q    <= '0;
        bit_q  <= '0;
        sh_q   <= tx;
        ack_q  <= 1'b0;
      end else if (busy_q && qtick) begin
        // mid-high sampling point is the end of quarter 1
        if (kind_q == K_BYTE && q_q == 2'd1) begin
          if (rd_q && bit_q != 4'd8)  sh_q  <= {sh_q[6:0], sda_in};
          if (!rd_q && bit_q == 4'd8) ack_q <= !sda_in;
        end
        if (kind_q == K_BYTE && q_q == 2'd3 && !rd_q && bit_q != 4'd8)
          sh_q <= {sh_q[6:0], 1'b0};
        q_q <= q_q + 2'd1;
        if (kind_q == K_BYTE && q_q == 2'd3 && bit_q != 4'd8)
          bit_q <= bit_q + 4'd1;
        if (last_q) begin
          busy_q     <= 1'b0;
          done_q     <= 1'b1;
          idle_scl_q <= pat[1];
          idle_sda_q <= pat[0];
          case (kind_q)
            K_START, K_RESTART: begin owned_q <= 1'b1; st_q <= ST_OK; end
            K_STOP: begin
              owned_q <= 1'b0;
              st_q    <= sda_in ? ST_OK : ST_ABORT;
            end
            default: begin
              st_q  <= rd_q ? ST_OK : (ack_q ? ST_ACK : ST_NOACK);
              rxl_q <= rd_q;
            end
          endcase
        end
      end
    end
  end

  assign busy    = busy_q;
  assign owned   = owned_q;
  assign done    = done_q;
  assign status  = st_q;
  assign rx      = sh_q;
  assign rx_load = rxl_q;

  // R4: no SDA change while SCL stays released during a byte
  a_r4_sda_steady: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (byte_phase && !scl_low) |=> (scl_low || $stable(sda_low)));
  // R5 / R11: start-type commands leave the bus owned
  a_r5_start_owns: assert property (@(posedge clk) disable iff (!rst_n || clr)
    ($fell(busy_q) && (kind_q == K_START || kind_q == K_RESTART)) |-> owned_q);
  // R8: a finished stop drops ownership and frees both wires
  a_r8_stop_frees: assert property (@(posedge clk) disable iff (!rst_n || clr)
    ($fell(busy_q) && kind_q == K_STOP) |-> (!owned_q && !scl_low && !sda_low));
endmodule

// File: rtl/i2c_cmd_master.sv
`timescale 1ns/1ps
module i2c_cmd_master import i2cm_pkg::*; #(
  parameter int QMULT = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq,
  output logic          scl_oe,
  input  logic          scl_in,
  output logic          sda_oe,
  input  logic          sda_in
);
  logic       ctrl_rst, ien_q, pend_q;
  logic [7:0] div_q, data_q;
  logic [3:0] op_q;

  logic       eng_busy, eng_owned, eng_done, eng_rxl, qtick, hold, go;
  logic [1:0] eng_status;
  logic [7:0] eng_rx;

  function automatic logic hit(input logic [AW-1:0] a, input logic [3:0] off);
    return a == AW'(off);
  endfunction

  assign go   = reg_we && hit(reg_addr, A_CMD) && reg_wdata[7] && !eng_busy && !ctrl_rst;
  assign hold = eng_busy && !scl_oe && !scl_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_rst <= 1'b0; ien_q <= 1'b0; pend_q <= 1'b0;
      div_q <= '0; data_q <= '0; op_q <= '0;
    end else begin
      if (reg_we && hit(reg_addr, A_CTRL)) ctrl_rst <= reg_wdata[0];
      if (reg_we && hit(reg_addr, A_DIV))  div_q    <= reg_wdata;
      if (reg_we && hit(reg_addr, A_IEN))  ien_q    <= reg_wdata[0];
      if (go) op_q <= reg_wdata[3:0];
      if (eng_rxl) data_q <= eng_rx;
      else if (reg_we && hit(reg_addr, A_DATA)) data_q <= reg_wdata;
      if (ctrl_rst)      pend_q <= 1'b0;
      else if (eng_done) pend_q <= 1'b1;
      else if (reg_we && hit(reg_addr, A_FCLR) && reg_wdata[0]) pend_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit(reg_addr, A_CTRL))      reg_rdata = {7'd0, ctrl_rst};
    else if (hit(reg_addr, A_DIV))  reg_rdata = div_q;
    else if (hit(reg_addr, A_CMD))  reg_rdata = {eng_busy, eng_status, 1'b0, op_q};
    else if (hit(reg_addr, A_DATA)) reg_rdata = data_q;
    else if (hit(reg_addr, A_IEN))  reg_rdata = {7'd0, ien_q};
  end

  assign irq = pend_q && ien_q;

  i2cm_qtick #(.DIV_W(8), .QMULT(QMULT)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(eng_busy), .hold(hold), .div(div_q), .qtick(qtick));

  i2cm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .clr(ctrl_rst), .go(go), .op(reg_wdata[3:0]),
    .tx(data_q), .qtick(qtick), .sda_in(sda_in), .busy(eng_busy), .owned(eng_owned),
    .done(eng_done), .status(eng_status), .rx(eng_rx), .rx_load(eng_rxl),
    .scl_low(scl_oe), .sda_low(sda_oe));

  // R1: soft reset idles the engine and drops the flag
  a_r1_soft_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rst |=> (!eng_busy && !pend_q && !scl_oe && !sda_oe));
  // R3: command writes while busy leave the opcode alone
  a_r3_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && reg_we && hit(reg_addr, A_CMD)) |=> $stable(op_q));
  // R9: non-start command without ownership aborts at once
  a_r9_unowned_abort: assert property (@(posedge clk) disable iff (!rst_n || ctrl_rst)
    (go && reg_wdata[3:0] != OP_START && !eng_owned) |=> (eng_done && eng_status == ST_ABORT));
  // R10: a completion always leaves the flag pending
  a_r10_done_flag: assert property (@(posedge clk) disable iff (!rst_n || ctrl_rst)
    eng_done |=> pend_q);
endmodule

// File: tb/i2c_cmd_master_tb_top.sv
`timescale 1ns/1ps
module i2c_cmd_master_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  wire  [7:0] rdata;
  wire        irq, scl_oe, sda_oe;

  logic       stretch = 1'b0, slv_stuck = 1'b0, slv_ack_en = 1'b0, slv_rd_en = 1'b0;
  logic [7:0] slv_byte = '0;
  int         fall_cnt = 0;

  wire scl_line = !scl_oe && !stretch;
  wire slv_low  = slv_stuck || (slv_ack_en && fall_cnt == 8) ||
                  (slv_rd_en && fall_cnt < 8 && !slv_byte[3'(7 - fall_cnt)]);
  wire sda_line = !sda_oe && !slv_low;

  i2c_cmd_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq(irq), .scl_oe(scl_oe), .scl_in(scl_line),
    .sda_oe(sda_oe), .sda_in(sda_line));

  int checks = 0, errors = 0, cyc = 0;
  int rise_n = 0, last_rise = 0, prev_rise = 0, starts = 0, stops = 0;
  logic [8:0] mon_bits = '0;
  int d_write = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge scl_line) begin
    prev_rise = last_rise; last_rise = cyc; rise_n++;
    mon_bits = {mon_bits[7:0], sda_line};
  end
  always @(negedge scl_line) fall_cnt++;
  always @(negedge sda_line) if (scl_line) starts++;
  always @(posedge sda_line) if (scl_line) stops++;

  always @(posedge clk) if (cyc > 150000) begin
    errors++;
    $display("FAIL watchdog actual=%0d cycles expected=<150000", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_idle(output int dur);
    logic [7:0] v;
    int t0 = cyc;
    do rd(4'h2, v); while (v[7]);
    dur = cyc - t0;
  endtask

  task automatic clear_mon();
    rise_n = 0; starts = 0; stops = 0; mon_bits = '0; fall_cnt = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 scl released", int'(scl_line), 1);
    chk("R1 sda released", int'(sda_line), 1);
    chk("R1 irq low", int'(irq), 0);
    rd(4'h2, v); chk("R1 cmd reg idle", v, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(4'h1, 8'h5A); rd(4'h1, v); chk("R2 divider readback", v, 8'h5A);
    wr(4'hA, 8'hFF); rd(4'hA, v); chk("R2 enable readback", v, 8'h01);
    wr(4'h3, 8'h77); rd(4'h3, v); chk("R2 data readback", v, 8'h77);
    wr(4'h1, 8'h00);
  endtask

  task automatic t_nogo();
    logic [7:0] v;
    clear_mon();
    wr(4'h2, 8'h01);
    repeat (5) @(negedge clk);
    rd(4'h2, v); chk("R3 no GO no launch", v, 8'h00);
    chk("R3 no GO no clocks", rise_n, 0);
  endtask

  task automatic t_unowned();
    logic [7:0] v;
    clear_mon();
    wr(4'h2, 8'h83); rd(4'h2, v);
    chk("R9 write unowned aborts", v, 8'h63);
    chk("R10 irq on completion", int'(irq), 1);
    chk("R9 no bus activity", rise_n + starts + stops, 0);
    wr(4'h8, 8'h01); @(negedge clk);
    chk("R10 flag clear", int'(irq), 0);
    wr(4'h2, 8'h85); rd(4'h2, v);
    chk("R9 unknown opcode aborts", v, 8'h65);
    wr(4'h8, 8'h01);
    wr(4'hA, 8'h00);
    wr(4'h2, 8'h8A); rd(4'h2, v);
    chk("R9 stop unowned aborts", v, 8'h6A);
    chk("R10 enable gates irq", int'(irq), 0);
    wr(4'hA, 8'h01); @(negedge clk);
    chk("R10 pending shows when enabled", int'(irq), 1);
    wr(4'h8, 8'h01);
  endtask

  task automatic t_start();
    logic [7:0] v; int d;
    clear_mon();
    wr(4'h2, 8'h81); rd(4'h2, v);
    chk("R3 busy after launch", v, 8'h81);
    wr(4'h2, 8'h8A);
    wait_idle(d);
    rd(4'h2, v); chk("R3 busy write ignored", v, 8'h01);
    chk("R5 one start condition", starts, 1);
    chk("R5 no stop condition", stops, 0);
    chk("R5 scl held low", int'(scl_line), 0);
    chk("R10 irq after start", int'(irq), 1);
    wr(4'h8, 8'h01);
  endtask

  task automatic t_write(input logic [7:0] b, input logic ack, input logic [7:0] exp_cmd,
                         output int dur);
    logic [7:0] v;
    wr(4'h3, b);
    clear_mon();
    slv_ack_en = ack;
    wr(4'h2, 8'h83);
    wait_idle(dur);
    slv_ack_en = 1'b0;
    chk("R6 nine clocks", rise_n, 9);
    chk("R6 bits on wire MSB first", int'(mon_bits), int'({b, !ack}));
    rd(4'h2, v); chk("R6 ack status", v, exp_cmd);
    chk("R4 bit period 64 clocks", last_rise - prev_rise, 64);
    chk("R4 sda steady while scl high", starts + stops, 0);
  endtask

  task automatic t_read(input logic [7:0] b, input logic [7:0] div, input logic [7:0] opw);
    logic [7:0] v; int d;
    wr(4'h1, div);
    clear_mon();
    slv_byte = b; slv_rd_en = 1'b1;
    wr(4'h2, opw);
    wait_idle(d);
    slv_rd_en = 1'b0;
    rd(4'h3, v); chk("R7 received byte", v, b);
    chk("R7 ninth bit ack or nack", int'(mon_bits[0]), (opw[3:0] == 4'd6) ? 0 : 1);
    rd(4'h2, v); chk("R7 status normal", v, {4'h0, opw[3:0]});
    chk("R4 bit period scales", last_rise - prev_rise, 64 * (int'(div) + 1));
    wr(4'h1, 8'h00);
  endtask

  task automatic t_restart();
    logic [7:0] v; int d;
    clear_mon();
    wr(4'h2, 8'h82); wait_idle(d);
    chk("R11 repeated start seen", starts, 1);
    chk("R11 no stop", stops, 0);
    chk("R11 one scl rise", rise_n, 1);
    rd(4'h2, v); chk("R11 status", v, 8'h02);
  endtask

  task automatic t_stretch();
    logic [7:0] v; int d; int t0;
    wr(4'h3, 8'h99);
    clear_mon();
    slv_ack_en = 1'b1; stretch = 1'b1;
    wr(4'h2, 8'h83);
    t0 = cyc;
    repeat (300) @(negedge clk);
    rd(4'h2, v);
    chk("R12 still busy while stretched", int'(v[7]), 1);
    chk("R12 no rise while stretched", rise_n, 0);
    stretch = 1'b0;
    wait_idle(d);
    slv_ack_en = 1'b0;
    chk_rng("R12 added delay", (cyc - t0) - d_write, 260, 300);
    chk("R12 data intact", int'(mon_bits), int'({8'h99, 1'b0}));
  endtask

  task automatic t_stop();
    logic [7:0] v; int d;
    clear_mon();
    wr(4'h2, 8'h8A); wait_idle(d);
    chk("R8 stop condition", stops, 1);
    chk("R8 lines released", int'(scl_line && sda_line), 1);
    rd(4'h2, v); chk("R8 stop status", v, 8'h0A);
  endtask

  task automatic t_stop_abort();
    logic [7:0] v; int d;
    wr(4'h2, 8'h81); wait_idle(d);
    slv_stuck = 1'b1;
    wr(4'h2, 8'h8A); wait_idle(d);
    rd(4'h2, v); chk("R8 stuck sda aborts stop", v, 8'h6A);
    slv_stuck = 1'b0;
    chk("R8 scl released", int'(scl_line), 1);
    wr(4'h2, 8'h83); rd(4'h2, v);
    chk("R8 ownership dropped", v, 8'h63);
  endtask

  task automatic t_soft();
    logic [7:0] v; int d;
    wr(4'h2, 8'h81); wait_idle(d);
    wr(4'h2, 8'h83);
    repeat (50) @(negedge clk);
    wr(4'h0, 8'h01);
    repeat (2) @(negedge clk);
    chk("R1 soft reset releases lines", int'(scl_line && sda_line), 1);
    rd(4'h2, v); chk("R1 soft reset idles", v, 8'h03);
    chk("R1 soft reset clears flag", int'(irq), 0);
    rd(4'h0, v); chk("R2 control readback", v, 8'h01);
    wr(4'h2, 8'h81);
    repeat (5) @(negedge clk);
    rd(4'h2, v); chk("R1 command ignored in reset", v, 8'h03);
    chk("R1 scl idle in reset", int'(scl_line), 1);
    wr(4'h0, 8'h00);
    wr(4'h2, 8'h83); rd(4'h2, v);
    chk("R1 ownership lost", v, 8'h63);
  endtask

  initial begin
    int d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_regs();
    t_nogo();
    t_unowned();
    t_start();
    t_write(8'hA5, 1'b1, 8'h23, d_write);
    t_write(8'h5E, 1'b0, 8'h43, d);
    t_read(8'h3C, 8'd1, 8'h86);
    t_read(8'hC3, 8'd0, 8'h87);
    t_restart();
    t_stretch();
    t_stop();
    t_stop_abort();
    t_soft();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule